// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing fields of a decoded instruction into the address of its memory operand for a 32-bit core. It takes a mode code, a base register value, an index register value, a signed displacement, a scale selector, an operand size, the address of the current instruction and an immediate. From these it produces the effective address and flags that mark operands held in a register or in the instruction. For the auto-stepping modes it also produces a base-register write-back value and its enable.

The result is registered, so every output follows its inputs by one clock edge. All arithmetic wraps modulo 2^32. The displacement is narrower than the address and is sign-extended before use. The register file and the memory port sit outside this block.

Top module: `eff_addr_gen`

## Requirements
- R1: While rst_ni is low, and on the first edge after it, ea_o, wb_val_o, wb_en_o, is_reg_o, is_imm_o and illegal_o are all zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: Mode 0 (register operand) sets is_reg_o, with ea_o zero and no write-back. Mode 1 (immediate operand) sets is_imm_o, with ea_o equal to imm_i and no write-back.
- R4: Mode 2 (absolute) gives ea_o = imm_i. Mode 3 (register indirect) gives ea_o = base_i.
- R5: Mode 4 (post-increment) gives ea_o = base_i and wb_val_o = base_i + N, with wb_en_o set. N is the operand byte count, where size_i 0/1/2/3 selects 1/2/4/8.
- R6: Mode 5 (pre-decrement) gives ea_o = wb_val_o = base_i - N, with wb_en_o set.
- R7: Mode 6 (displacement) gives ea_o = base_i + sext(disp_i), wrapping modulo 2^32.
- R8: Mode 7 (scaled index) gives ea_o = index_i * S, where scale_i 0/1/2/3/4 selects S = 1/2/4/8/16.
- R9: Mode 8 gives ea_o = base_i + index_i*S. Mode 9 gives ea_o = base_i + index_i*S + sext(disp_i).
- R10: Mode 10 (PC-relative) gives ea_o = pc_i + 4 + sext(disp_i). For example, pc 0x4000 with disp 0x400 gives 0x4404.
- R11: Mode codes 11 to 15, and scale_i codes 5 to 7 in modes 7, 8 or 9, set illegal_o. In those cases ea_o, wb_val_o, wb_en_o, is_reg_o and is_imm_o are all zero.
- R12: wb_en_o is set only for modes 4 and 5. In every other mode wb_val_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Addressing mode code |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| disp_i | input | 16 | Signed displacement |
| scale_i | input | 3 | Index scale selector |
| size_i | input | 2 | Operand size code |
| pc_i | input | 32 | Address of the current instruction |
| imm_i | input | 32 | Immediate value or absolute address |
| ea_o | output | 32 | Effective address (the immediate in mode 1) |
| is_reg_o | output | 1 | Operand is held in a register |
| is_imm_o | output | 1 | Operand is held in the instruction |
| wb_en_o | output | 1 | Base register write-back enable |
| wb_val_o | output | 32 | Base register write-back value |
| illegal_o | output | 1 | Mode or scale code is not defined |

## Verification
The bench steps post-increment and pre-decrement through all four operand sizes. A design that used a fixed step, or that took the address after the update in the wrong mode, would give wrong ea_o or wb_val_o values. Negative displacements and sums that wrap past 2^32 catch a design that zero-extends the displacement or that saturates. Every scale code is applied, including the undefined ones, to expose a shift that is off by one or an out-of-range scale that is silently accepted. PC-relative targets are checked against the advanced PC, so a design that adds the displacement to the raw instruction address misses by four.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    MODE_REG     = 4'd0,
    MODE_IMM     = 4'd1,
    MODE_ABS     = 4'd2,
    MODE_IND     = 4'd3,
    MODE_POSTINC = 4'd4,
    MODE_PREDEC  = 4'd5,
    MODE_DISP    = 4'd6,
    MODE_SIDX    = 4'd7,
    MODE_BSIDX   = 4'd8,
    MODE_BSIDXD  = 4'd9,
    MODE_PCREL   = 4'd10
  } mode_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_BASE = 2'd1,
    SRC_PC4  = 2'd2,
    SRC_IMM  = 2'd3
  } src_e;

  typedef struct packed {
    src_e src_a;
    logic add_idx;
    logic add_disp;
    logic sub_step;
    logic add_step_wb;
    logic wb;
    logic is_reg;
    logic is_imm;
    logic uses_scale;
    logic bad_mode;
  } ctrl_t;

  localparam int unsigned PC_ADVANCE = 4;

  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction
endpackage

// File: rtl/eag_mode_dec.sv
module eag_mode_dec
  import eag_pkg::*;
(
  input  logic [3:0] mode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    ctrl_o.src_a = SRC_ZERO;
    case (mode_i)
      MODE_REG:     ctrl_o.is_reg = 1'b1;
      MODE_IMM:     begin ctrl_o.is_imm = 1'b1; ctrl_o.src_a = SRC_IMM; end
      MODE_ABS:     ctrl_o.src_a = SRC_IMM;
      MODE_IND:     ctrl_o.src_a = SRC_BASE;
      MODE_POSTINC: begin
        ctrl_o.src_a = SRC_BASE;
        ctrl_o.wb = 1'b1;
        ctrl_o.add_step_wb = 1'b1;
      end
      MODE_PREDEC:  begin
        ctrl_o.src_a = SRC_BASE;
        ctrl_o.wb = 1'b1;
        ctrl_o.sub_step = 1'b1;
      end
      MODE_DISP:    begin ctrl_o.src_a = SRC_BASE; ctrl_o.add_disp = 1'b1; end
      MODE_SIDX:    begin ctrl_o.add_idx = 1'b1; ctrl_o.uses_scale = 1'b1; end
      MODE_BSIDX:   begin
        ctrl_o.src_a = SRC_BASE;
        ctrl_o.add_idx = 1'b1;
        ctrl_o.uses_scale = 1'b1;
      end
      MODE_BSIDXD:  begin
        ctrl_o.src_a = SRC_BASE;
        ctrl_o.add_idx = 1'b1;
        ctrl_o.add_disp = 1'b1;
        ctrl_o.uses_scale = 1'b1;
      end
      MODE_PCREL:   begin ctrl_o.src_a = SRC_PC4; ctrl_o.add_disp = 1'b1; end
      default:      ctrl_o.bad_mode = 1'b1;
    endcase
  end
endmodule

// File: rtl/eag_index_scale.sv
module eag_index_scale #(
  parameter int unsigned AW      = 32,
  parameter int unsigned SCALE_N = 5,
  localparam int unsigned SW     = $clog2(SCALE_N)
) (
  input  logic [AW-1:0] index_i,
  input  logic [SW-1:0] scale_i,
  output logic [AW-1:0] scaled_o,
  output logic          bad_o
);
  logic [AW-1:0] cand [SCALE_N];

  for (genvar g = 0; g < SCALE_N; g++) begin : g_shift
    assign cand[g] = index_i << g;
  end

  always_comb begin
    scaled_o = '0;
    bad_o    = 1'b1;
    for (int i = 0; i < SCALE_N; i++) begin
      if (scale_i == SW'(i)) begin
        scaled_o = cand[i];
        bad_o    = 1'b0;
      end
    end
  end
endmodule

// File: rtl/eag_sum.sv
module eag_sum
  import eag_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  ctrl_t         ctrl_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] imm_i,
  input  logic [AW-1:0] scaled_i,
  input  logic [AW-1:0] disp_x_i,
  input  logic [AW-1:0] step_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] wb_val_o
);
  logic [AW-1:0] term_a, term_b, term_c;

  always_comb begin
    unique case (ctrl_i.src_a)
      SRC_BASE: term_a = base_i;
      SRC_PC4:  term_a = pc_i + AW'(PC_ADVANCE);
      SRC_IMM:  term_a = imm_i;
      default:  term_a = '0;
    endcase
    term_b = ctrl_i.add_idx ? scaled_i : '0;
    if (ctrl_i.add_disp)      term_c = disp_x_i;
    else if (ctrl_i.sub_step) term_c = -step_i;
    else                      term_c = '0;
  end

  assign ea_o = term_a + term_b + term_c;

  always_comb begin
    if (!ctrl_i.wb)               wb_val_o = '0;
    else if (ctrl_i.add_step_wb)  wb_val_o = base_i + step_i;
    else                          wb_val_o = ea_o;
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned DISP_W  = 16,
  parameter int unsigned SCALE_N = 5,
  localparam int unsigned SW     = $clog2(SCALE_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        mode_i,
  input  logic [AW-1:0]     base_i,
  input  logic [AW-1:0]     index_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [SW-1:0]     scale_i,
  input  logic [1:0]        size_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [AW-1:0]     imm_i,
  output logic [AW-1:0]     ea_o,
  output logic              is_reg_o,
  output logic              is_imm_o,
  output logic              wb_en_o,
  output logic [AW-1:0]     wb_val_o,
  output logic              illegal_o
);
  ctrl_t         ctrl;
  logic [AW-1:0] scaled, disp_x, step, ea_d, wb_d;
  logic          scale_bad, illegal_d;

  eag_mode_dec u_dec (.mode_i(mode_i), .ctrl_o(ctrl));

  eag_index_scale #(.AW(AW), .SCALE_N(SCALE_N)) u_scale (
    .index_i (index_i),
    .scale_i (scale_i),
    .scaled_o(scaled),
    .bad_o   (scale_bad)
  );

  assign disp_x = {{(AW-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign step   = AW'(size_bytes(size_i));

  eag_sum #(.AW(AW)) u_sum (
    .ctrl_i  (ctrl),
    .base_i  (base_i),
    .pc_i    (pc_i),
    .imm_i   (imm_i),
    .scaled_i(scaled),
    .disp_x_i(disp_x),
    .step_i  (step),
    .ea_o    (ea_d),
    .wb_val_o(wb_d)
  );

  assign illegal_d = ctrl.bad_mode | (ctrl.uses_scale & scale_bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_o      <= '0;
      is_reg_o  <= 1'b0;
      is_imm_o  <= 1'b0;
      wb_en_o   <= 1'b0;
      wb_val_o  <= '0;
      illegal_o <= 1'b0;
    end else if (illegal_d) begin
      ea_o      <= '0;
      is_reg_o  <= 1'b0;
      is_imm_o  <= 1'b0;
      wb_en_o   <= 1'b0;
      wb_val_o  <= '0;
      illegal_o <= 1'b1;
    end else begin
      ea_o      <= ea_d;
      is_reg_o  <= ctrl.is_reg;
      is_imm_o  <= ctrl.is_imm;
      wb_en_o   <= ctrl.wb;
      wb_val_o  <= wb_d;
      illegal_o <= 1'b0;
    end
  end

  // operand-class flags are mutually exclusive
  a_r11_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({is_reg_o, is_imm_o, illegal_o, wb_en_o}));

  a_r11_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (ea_o == '0 && wb_val_o == '0 && !wb_en_o));

  a_r12_wb_only_auto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) or 1'b1 |=> (wb_en_o |->
      ($past(mode_i) == MODE_POSTINC || $past(mode_i) == MODE_PREDEC)));

  a_r5_postinc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i) == MODE_POSTINC && $past(rst_ni) |->
      (wb_val_o - ea_o == AW'(size_bytes($past(size_i))) && wb_en_o));

  a_r6_predec_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i) == MODE_PREDEC && $past(rst_ni) |->
      (wb_en_o && ea_o == wb_val_o && $past(base_i) - ea_o == AW'(size_bytes($past(size_i)))));

  a_r10_pcrel_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(mode_i) == MODE_PCREL && $past(rst_ni) |->
      (ea_o - $past(pc_i) - AW'(PC_ADVANCE) ==
       {{(AW-DISP_W){$past(disp_i[DISP_W-1])}}, $past(disp_i)}));
endmodule

// File: tb/eff_addr_gen_test.sv
module eff_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = '0;
  logic [31:0] base = '0, index = '0, pc = '0, imm = '0;
  logic [15:0] disp = '0;
  logic [2:0]  scale = '0;
  logic [1:0]  size = '0;
  logic [31:0] ea, wb_val;
  logic        is_reg, is_imm, wb_en, illegal;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eff_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .base_i(base), .index_i(index),
    .disp_i(disp), .scale_i(scale), .size_i(size), .pc_i(pc), .imm_i(imm),
    .ea_o(ea), .is_reg_o(is_reg), .is_imm_o(is_imm), .wb_en_o(wb_en),
    .wb_val_o(wb_val), .illegal_o(illegal)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // apply inputs after a falling edge; results read at the next falling edge
  task automatic apply(input logic [3:0] m, input logic [31:0] b, input logic [31:0] x,
                       input logic [15:0] d, input logic [2:0] s, input logic [1:0] z,
                       input logic [31:0] p, input logic [31:0] i);
    mode = m; base = b; index = x; disp = d; scale = s; size = z; pc = p; imm = i;
    @(negedge clk);
  endtask

  task automatic expect_all(input string req, input logic [31:0] e_ea, input logic e_reg,
                            input logic e_imm, input logic e_wb, input logic [31:0] e_wbv,
                            input logic e_ill);
    chk({req, " ea"}, ea, e_ea);
    chk({req, " is_reg"}, {31'b0, is_reg}, {31'b0, e_reg});
    chk({req, " is_imm"}, {31'b0, is_imm}, {31'b0, e_imm});
    chk({req, " wb_en"}, {31'b0, wb_en}, {31'b0, e_wb});
    chk({req, " wb_val"}, wb_val, e_wbv);
    chk({req, " illegal"}, {31'b0, illegal}, {31'b0, e_ill});
  endtask

  task automatic t_reset;
    mode = 4'd4; base = 32'h1234; // active stimulus must be masked by reset
    @(negedge clk); @(negedge clk);
    expect_all("R1", 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_reg_imm;
    apply(4'd0, 32'hAAAA_0000, 32'h5, 16'h7, 3'd1, 2'd2, 32'h100, 32'hDEAD_BEEF);
    expect_all("R3 reg", 32'h0, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0);
    apply(4'd1, 32'hAAAA_0000, 32'h5, 16'h7, 3'd1, 2'd2, 32'h100, 32'hDEAD_BEEF);
    expect_all("R3 imm", 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_abs_ind;
    apply(4'd2, 32'h1111_2222, 32'h0, 16'h0, 3'd0, 2'd0, 32'h0, 32'h0000_AAF0);
    expect_all("R4 abs", 32'h0000_AAF0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    apply(4'd3, 32'h1111_2222, 32'h0, 16'h0, 3'd0, 2'd0, 32'h0, 32'h0000_AAF0);
    expect_all("R4 ind", 32'h1111_2222, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_postinc;
    for (int z = 0; z < 4; z++) begin
      apply(4'd4, 32'h0000_1000, 32'h0, 16'h0, 3'd0, 2'(z), 32'h0, 32'h0);
      expect_all("R5", 32'h0000_1000, 1'b0, 1'b0, 1'b1, 32'h0000_1000 + (32'd1 << z), 1'b0);
    end
    apply(4'd4, 32'hFFFF_FFFE, 32'h0, 16'h0, 3'd0, 2'd2, 32'h0, 32'h0);
    expect_all("R5 wrap", 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b1, 32'h0000_0002, 1'b0);
  endtask

  task automatic t_predec;
    for (int z = 0; z < 4; z++) begin
      apply(4'd5, 32'h0000_2000, 32'h0, 16'h0, 3'd0, 2'(z), 32'h0, 32'h0);
      expect_all("R6", 32'h0000_2000 - (32'd1 << z), 1'b0, 1'b0, 1'b1,
                 32'h0000_2000 - (32'd1 << z), 1'b0);
    end
    apply(4'd5, 32'h0000_0001, 32'h0, 16'h0, 3'd0, 2'd1, 32'h0, 32'h0);
    expect_all("R6 wrap", 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_disp;
    apply(4'd6, 32'h0000_0100, 32'h0, 16'd125, 3'd0, 2'd0, 32'h0, 32'h0);
    expect_all("R7 pos", 32'h0000_017D, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    apply(4'd6, 32'h0000_0100, 32'h0, 16'hFFF0, 3'd0, 2'd0, 32'h0, 32'h0);
    expect_all("R7 neg", 32'h0000_00F0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    apply(4'd6, 32'hFFFF_FFF0, 32'h0, 16'h0020, 3'd0, 2'd0, 32'h0, 32'h0);
    expect_all("R7 wrap", 32'h0000_0010, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_scaled;
    for (int s = 0; s < 5; s++) begin
      apply(4'd7, 32'h9999_9999, 32'h0000_0013, 16'h0, 3'(s), 2'd0, 32'h0, 32'h0);
      expect_all("R8", 32'h13 << s, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    end
  endtask

  task automatic t_base_idx;
    apply(4'd8, 32'h0000_1000, 32'h0000_0010, 16'h0040, 3'd1, 2'd0, 32'h0, 32'h0);
    expect_all("R9 b+i", 32'h0000_1020, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    apply(4'd9, 32'h0000_1000, 32'h0000_0010, 16'hFFFC, 3'd4, 2'd0, 32'h0, 32'h0);
    expect_all("R9 b+i+d", 32'h0000_10FC, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_pcrel;
    apply(4'd10, 32'h5555_0000, 32'h0, 16'h0400, 3'd0, 2'd0, 32'h0000_4000, 32'h0);
    expect_all("R10 fwd", 32'h0000_4404, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
    apply(4'd10, 32'h5555_0000, 32'h0, 16'hFFF8, 3'd0, 2'd0, 32'h0000_4000, 32'h0);
    expect_all("R10 back", 32'h0000_3FFC, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_illegal;
    for (int m = 11; m < 16; m++) begin
      apply(4'(m), 32'h1234_5678, 32'h1, 16'h1, 3'd0, 2'd2, 32'h10, 32'h20);
      expect_all("R11 mode", 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
    end
    for (int s = 5; s < 8; s++) begin
      apply(4'd8, 32'h1234_5678, 32'h1, 16'h1, 3'(s), 2'd0, 32'h0, 32'h0);
      expect_all("R11 scale", 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b1);
    end
    // scale code outside scaled modes is ignored
    apply(4'd3, 32'h0000_0ABC, 32'h1, 16'h1, 3'd7, 2'd0, 32'h0, 32'h0);
    expect_all("R11 scale unused", 32'h0000_0ABC, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic t_latency;
    // R2: output holds the previous vector until the edge
    mode = 4'd3; base = 32'h0000_00A0;
    @(negedge clk);
    base = 32'h0000_00B0;
    #1 chk("R2 hold", ea, 32'h0000_00A0);
    @(negedge clk);
    chk("R2 update", ea, 32'h0000_00B0);
  endtask

  task automatic t_wb_absent;
    for (int m = 0; m < 11; m++) begin
      if (m == 4 || m == 5) continue;
      apply(4'(m), 32'h0000_4000, 32'h2, 16'h8, 3'd1, 2'd3, 32'h100, 32'h200);
      chk("R12 wb_en", {31'b0, wb_en}, 32'h0);
      chk("R12 wb_val", wb_val, 32'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_reg_imm();
    t_abs_ind();
    t_postinc();
    t_predec();
    t_disp();
    t_scaled();
    t_base_idx();
    t_pcrel();
    t_illegal();
    t_latency();
    t_wb_absent();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule